// File: doc/BRIEF.md
# Vector Memory Request Address Generator

This block turns one vector load or store command into a stream of per-element memory requests. It supports three addressing patterns. In unit-stride mode the addresses are consecutive. In constant-stride mode each element advances the address by a fixed stride. In indexed mode, used for gather and scatter, each element address is a base plus an offset vector entry. The index entries arrive one per cycle on a valid/ready pair. The element count comes from a length value sampled when the command starts, and it is capped at the maximum vector length of 64.

Every request carries its element number, a 32-bit element address and the number of the bank that serves it. Memory is modelled as eight banks interleaved on the low address bits. The block also raises a conflict flag on any request whose bank was already used by one of the seven requests accepted just before it in the same command. A stride of 2 or 4 shows up here as a run of flagged requests, while an odd stride produces none. The controlling pipeline pulses a start input, drains requests through a valid/ready handshake, and waits for the done flag.

Top module: `vec_addr_gen`

## Requirements
- R1: While reset is held and after its release, busy_o, req_valid_o and done_o are low, and they stay low until a start is accepted.
- R2: In mode 0 (unit stride), element i is requested at base + i. Mode 3 behaves exactly like mode 0.
- R3: In mode 1 (constant stride), element i is requested at base + i×stride. The sum wraps modulo 2^32, so a stride of all ones walks the addresses downward.
- R4: In mode 2 (indexed), the address is base + idx_data_i, summed modulo 2^32. req_valid_o follows idx_valid_i while busy, and idx_ready_o equals req_ready_i while busy in this mode and is low in every other case.
- R5: A command issues exactly min(len_i, 64) requests, numbered 0 upward, and the element number advances only on a cycle in which req_valid_o and req_ready_i are both high.
- R6: req_bank_o equals bits [2:0] of req_addr_o.
- R7: req_conflict_o is high exactly when the request's bank matches the bank of any of the up to 7 most recent accepted requests of the same command. The bank history empties when a start is accepted.
- R8: While req_valid_o is high and req_ready_i is low, the element number, address and bank held on the request outputs do not change (in indexed mode the index input is also held).
- R9: done_o rises in the cycle after the final request is accepted and stays high, with busy_o low, until the next start is accepted. A start with length 0 issues no request and sets done_o in the next cycle.
- R10: A start pulse that arrives while busy_o is high is ignored. The running command continues with its own mode, base, stride and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command start pulse, sampled while idle |
| mode_i | input | 2 | 0 unit stride, 1 constant stride, 2 indexed, 3 as unit |
| base_i | input | 32 | Base element address |
| stride_i | input | 32 | Stride for mode 1 |
| len_i | input | 7 | Requested element count, capped at 64 |
| idx_valid_i | input | 1 | Index entry present |
| idx_data_i | input | 32 | Index entry (offset from base) |
| idx_ready_o | output | 1 | Index entry consumed |
| req_valid_o | output | 1 | Request present |
| req_ready_i | input | 1 | Request accepted by memory side |
| req_elem_o | output | 6 | Element number of the request |
| req_addr_o | output | 32 | Element address of the request |
| req_bank_o | output | 3 | Interleaved bank of the request |
| req_conflict_o | output | 1 | Bank reused within the last 7 accepted requests |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Last command finished |

## Verification
The bench targets the cases where the stride hits banks unevenly. Strides of 2, 4 and 8 must raise the conflict flag from the right element onward, and odd strides must never raise it. A history that was not cleared at start, or that was one entry too short or too long, would show up as a flag on the wrong element. Two stimuli test wraparound modulo 2^32: a base near the top of the address space, and a stride of all ones. A design that saturated or mis-sized its adder would return wrong addresses there. Lengths of 0 and 100 check the empty command and the cap at 64, where a wrong comparison would issue extra or missing requests or never assert done. Irregular ready and index-valid patterns, together with a second start during a busy command, catch a design that advances on a stall or restarts midway.

// File: rtl/vag_pkg.sv
package vag_pkg;
  typedef enum logic [1:0] {
    AM_UNIT   = 2'd0,
    AM_STRIDE = 2'd1,
    AM_INDEX  = 2'd2,
    AM_RSVD   = 2'd3
  } amode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } gst_e;
endpackage

// File: rtl/vag_ctrl.sv
module vag_ctrl
  import vag_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int LEN_W  = $clog2(MAX_VL + 1),
  localparam int ELEM_W = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              idx_valid_i,
  input  logic              req_ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              req_valid_o,
  output logic              idx_ready_o,
  output logic              launch_o,
  output logic              fire_o,
  output logic [ELEM_W-1:0] elem_o,
  output amode_e            mode_o
);
  gst_e              state_q, state_d;
  logic [ELEM_W-1:0] elem_q, elem_d;
  logic [LEN_W-1:0]  len_q, len_d, len_eff;
  amode_e            mode_q, mode_d;
  logic              done_q, done_d;
  logic              upd_en, is_last, running;

  assign running  = (state_q == ST_RUN);
  assign launch_o = (state_q == ST_IDLE) && start_i;
  assign len_eff  = (len_i > LEN_W'(MAX_VL)) ? LEN_W'(MAX_VL) : len_i;

  assign req_valid_o = running && ((mode_q != AM_INDEX) || idx_valid_i);
  assign idx_ready_o = running && (mode_q == AM_INDEX) && req_ready_i;
  assign fire_o      = req_valid_o && req_ready_i;
  assign is_last     = ((LEN_W'(elem_q) + LEN_W'(1)) == len_q);
  assign upd_en      = launch_o || fire_o;

  always_comb begin
    state_d = state_q;
    elem_d  = elem_q;
    len_d   = len_q;
    mode_d  = mode_q;
    done_d  = done_q;
    if (launch_o) begin
      mode_d = amode_e'(mode_i);
      len_d  = len_eff;
      elem_d = '0;
      if (len_eff == '0) begin
        done_d = 1'b1;
      end else begin
        done_d  = 1'b0;
        state_d = ST_RUN;
      end
    end else if (fire_o) begin
      if (is_last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end else begin
        elem_d = elem_q + ELEM_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      elem_q  <= '0;
      len_q   <= '0;
      mode_q  <= AM_UNIT;
      done_q  <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_d;
      elem_q  <= elem_d;
      len_q   <= len_d;
      mode_q  <= mode_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = running;
  assign done_o = done_q;
  assign elem_o = elem_q;
  assign mode_o = mode_q;

  p_valid_needs_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> busy_o);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  p_hold_elem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (busy_o && elem_o == $past(elem_o)));
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !fire_o) |=> (busy_o && elem_o == $past(elem_o)));
  p_elem_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> (done_o || elem_o == $past(elem_o) + ELEM_W'(1)));
endmodule

// File: rtl/vag_addr.sv
module vag_addr
  import vag_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch_i,
  input  logic          fire_i,
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] stride_i,
  input  amode_e        mode_q_i,
  input  logic [AW-1:0] idx_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] base_q, base_d;
  logic [AW-1:0] step_q, step_d;
  logic [AW-1:0] cur_q, cur_d;
  logic          upd_en;

  assign upd_en = launch_i || fire_i;

  always_comb begin
    base_d = base_q;
    step_d = step_q;
    cur_d  = cur_q;
    if (launch_i) begin
      base_d = base_i;
      cur_d  = base_i;
      step_d = (amode_e'(mode_i) == AM_STRIDE) ? stride_i : AW'(1);
    end else if (fire_i) begin
      cur_d = cur_q + step_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
      cur_q  <= '0;
    end else if (upd_en) begin
      base_q <= base_d;
      step_q <= step_d;
      cur_q  <= cur_d;
    end
  end

  assign addr_o = (mode_q_i == AM_INDEX) ? (base_q + idx_i) : cur_q;

  p_stride_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && mode_q_i != AM_INDEX) |=> (cur_q == $past(cur_q) + $past(step_q)));
  p_hold_cursor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!launch_i && !fire_i) |=> $stable(cur_q));
endmodule

// File: rtl/vag_bank_hist.sv
module vag_bank_hist #(
  parameter int BANK_W = 3,
  parameter int DEPTH  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              push_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              hit_o
);
  logic [DEPTH-1:0]  hv_q, hv_d;
  logic [BANK_W-1:0] hb_q [DEPTH];
  logic [BANK_W-1:0] hb_d [DEPTH];
  logic [DEPTH-1:0]  match;
  logic              upd_en;

  assign upd_en = clear_i || push_i;

  always_comb begin
    hv_d = hv_q;
    for (int k = 0; k < DEPTH; k++) hb_d[k] = hb_q[k];
    if (clear_i) begin
      hv_d = '0;
    end else if (push_i) begin
      hv_d = {hv_q[DEPTH-2:0], 1'b1};
      hb_d[0] = bank_i;
      for (int k = 1; k < DEPTH; k++) hb_d[k] = hb_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_q <= '0;
      for (int k = 0; k < DEPTH; k++) hb_q[k] <= '0;
    end else if (upd_en) begin
      hv_q <= hv_d;
      for (int k = 0; k < DEPTH; k++) hb_q[k] <= hb_d[k];
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign match[g] = hv_q[g] && (hb_q[g] == bank_i);
    end
  endgenerate

  assign hit_o = |match;

  p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (hv_q == '0));
  p_push_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !clear_i) |=> hv_q[0]);
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
  import vag_pkg::*;
#(
  parameter int AW     = 32,
  parameter int MAX_VL = 64,
  parameter int NBANK  = 8,
  localparam int LEN_W  = $clog2(MAX_VL + 1),
  localparam int ELEM_W = $clog2(MAX_VL),
  localparam int BANK_W = $clog2(NBANK),
  localparam int HDEPTH = NBANK - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [AW-1:0]     base_i,
  input  logic [AW-1:0]     stride_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              idx_valid_i,
  input  logic [AW-1:0]     idx_data_i,
  output logic              idx_ready_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ELEM_W-1:0] req_elem_o,
  output logic [AW-1:0]     req_addr_o,
  output logic [BANK_W-1:0] req_bank_o,
  output logic              req_conflict_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [1:0] rsync_q;
  logic       rst_int_n;
  logic       launch, fire;
  amode_e     mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  vag_ctrl #(.MAX_VL(MAX_VL)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start_i(start_i), .mode_i(mode_i),
    .len_i(len_i), .idx_valid_i(idx_valid_i), .req_ready_i(req_ready_i),
    .busy_o(busy_o), .done_o(done_o), .req_valid_o(req_valid_o),
    .idx_ready_o(idx_ready_o), .launch_o(launch), .fire_o(fire),
    .elem_o(req_elem_o), .mode_o(mode_q)
  );

  vag_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_int_n), .launch_i(launch), .fire_i(fire),
    .mode_i(mode_i), .base_i(base_i), .stride_i(stride_i),
    .mode_q_i(mode_q), .idx_i(idx_data_i), .addr_o(req_addr_o)
  );

  assign req_bank_o = req_addr_o[BANK_W-1:0];

  vag_bank_hist #(.BANK_W(BANK_W), .DEPTH(HDEPTH)) u_hist (
    .clk(clk), .rst_n(rst_int_n), .clear_i(launch), .push_i(fire),
    .bank_i(req_bank_o), .hit_o(req_conflict_o)
  );

  p_first_clean_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid_o && req_elem_o == '0) |-> !req_conflict_o);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy_o |-> (!req_valid_o && !idx_ready_o));
endmodule

// File: tb/sim_vec_addr_gen.sv
`timescale 1ns/1ps
module sim_vec_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  mode;
  logic [31:0] base, stride, idx_data;
  logic [6:0]  len;
  logic        idx_valid, req_ready;
  logic        idx_ready, req_valid, req_conflict, busy, done;
  logic [5:0]  req_elem;
  logic [31:0] req_addr;
  logic [2:0]  req_bank;

  always #2.5 clk = ~clk;

  vec_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .base_i(base),
    .stride_i(stride), .len_i(len), .idx_valid_i(idx_valid),
    .idx_data_i(idx_data), .idx_ready_o(idx_ready), .req_valid_o(req_valid),
    .req_ready_i(req_ready), .req_elem_o(req_elem), .req_addr_o(req_addr),
    .req_bank_o(req_bank), .req_conflict_o(req_conflict), .busy_o(busy),
    .done_o(done)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;

  // behavioural reference state
  bit          m_busy, m_done;
  int          m_mode, m_len, m_elem;
  logic [31:0] m_base, m_stride;
  int          hist[$];

  function automatic logic [31:0] exp_addr();
    if (m_mode == 2) return m_base + idx_data;
    if (m_mode == 1) return m_base + m_stride * 32'(m_elem);
    return m_base + 32'(m_elem);
  endfunction

  function automatic bit exp_valid();
    return m_busy && (m_mode != 2 || idx_valid);
  endfunction

  function automatic bit exp_conf();
    int b = int'(exp_addr() & 32'h7);
    foreach (hist[k]) if (hist[k] == b) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_mode = 0; m_len = 0; m_elem = 0;
      m_base = 0; m_stride = 0; hist.delete();
    end else if (!m_busy && start) begin
      m_mode   = int'(mode);
      m_base   = base;
      m_stride = stride;
      m_len    = (int'(len) > 64) ? 64 : int'(len);
      m_elem   = 0;
      hist.delete();
      m_busy   = (m_len != 0);
      m_done   = (m_len == 0);
    end else if (m_busy && exp_valid() && req_ready) begin
      hist.push_back(int'(exp_addr() & 32'h7));
      if (hist.size() > 7) void'(hist.pop_front());
      if (m_elem == m_len - 1) begin
        m_busy = 0; m_done = 1;
      end else begin
        m_elem++;
      end
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      string atag;
      atag = (m_mode == 2) ? "R4" : (m_mode == 1) ? "R3" : "R2";
      check(busy === m_busy, "R10", "busy", busy, m_busy);
      check(done === m_done, "R9", "done", done, m_done);
      check(req_valid === exp_valid(), "R5", "req_valid", req_valid, exp_valid());
      check(idx_ready === (m_busy && m_mode == 2 && req_ready), "R4", "idx_ready",
            idx_ready, (m_busy && m_mode == 2 && req_ready));
      if (exp_valid()) begin
        check(req_elem === 6'(m_elem), "R5", "elem", req_elem, m_elem);
        check(req_addr === exp_addr(), atag, "addr", req_addr, exp_addr());
        check(req_bank === exp_addr() % 8, "R6", "bank", req_bank, exp_addr() % 8);
        check(req_conflict === exp_conf(), "R7", "conflict", req_conflict, exp_conf());
      end
    end
  end

  // rpat selects the ready pattern; stalls exercise R8
  task automatic run_op(int md, logic [31:0] b, logic [31:0] s, int ln,
                        int rpat, bit inject);
    int k = 0;
    @(negedge clk);
    mode = 2'(md); base = b; stride = s; len = 7'(ln); start = 1'b1;
    forever begin
      @(negedge clk);
      start = 1'b0;
      if (!m_busy) break;
      case (rpat)
        0: req_ready = 1'b1;
        1: req_ready = (k % 3) != 1;
        default: req_ready = ((k * 7) % 5) != 0;
      endcase
      idx_valid = (k % 4) != 2;
      idx_data  = (k & 1) ? (32'hFFFF_FFF0 + 32'(k)) : 32'(k * 13);
      if (inject && k == 3) begin
        // R10: start while busy with different parameters
        start = 1'b1; mode = 2'd1; base = 32'h5555; stride = 32'd5; len = 7'd2;
      end
      k++;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    start = 0; mode = 0; base = 0; stride = 0; len = 0;
    idx_valid = 0; idx_data = 0; req_ready = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check(busy === 1'b0, "R1", "busy in reset", busy, 0);
    check(req_valid === 1'b0, "R1", "valid in reset", req_valid, 0);
    check(done === 1'b0, "R1", "done in reset", done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(busy === 1'b0 && done === 1'b0, "R1", "idle after release",
          {busy, done}, 0);

    run_op(0, 32'd100, 32'd0, 10, 0, 0);             // R2 unit stride
    run_op(1, 32'd0, 32'd2, 12, 1, 1);               // R3 stride 2, R7, R10
    run_op(1, 32'd40, 32'd3, 16, 2, 0);              // R7 odd stride, no conflict
    run_op(1, 32'd7, 32'd4, 10, 0, 0);               // R7 stride 4
    run_op(1, 32'd5, 32'hFFFF_FFFF, 9, 1, 0);        // R3 downward wrap
    run_op(0, 32'hFFFF_FFFC, 32'd0, 8, 2, 0);        // R2 wrap past 2^32
    run_op(2, 32'd1000, 32'd0, 20, 1, 0);            // R4 gather with gaps
    run_op(2, 32'h10, 32'd0, 9, 2, 1);               // R4 with ignored start
    run_op(1, 32'd0, 32'd9, 0, 0, 0);                // R9 empty command
    run_op(1, 32'd3, 32'd8, 100, 2, 0);              // R5 cap at 64, all conflict
    run_op(3, 32'd64, 32'd77, 11, 1, 0);             // R2 mode 3 as unit
    run_op(0, 32'd0, 32'd0, 64, 0, 0);               // R5 full length

    #1;
    check(done === 1'b1 && busy === 1'b0, "R9", "done held at end", {busy, done}, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule